// File: doc/BRIEF.md
# Host Keyboard Controller Register Interface

This block is the host-facing side of a keyboard controller. A CPU reaches it through two byte-wide ports: a data port and a command/status port. It holds a one-byte input buffer written by the CPU and a one-byte output buffer read by the CPU. It also holds a status byte, a controller configuration byte and a controller output port. The configuration byte enables the interrupt, sets the system flag and inhibits the keyboard and auxiliary clocks. The output port drives the system reset and the address-line-20 gate.

Every CPU write lands in the input buffer, tagged as command or data. The controller consumes it in the following cycle. Commands read or modify the internal registers, load the output buffer, or arm a wait for the next data byte. A data byte that arrives while such a wait is armed goes into the selected register. Otherwise it is forwarded to the keyboard as a one-cycle transmit strobe. Bytes from the device side fill the output buffer when it is empty. A command in the F0h–FFh range holds selected output-port lines low for a fixed number of cycles.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset the status byte reads 00h, the configuration byte is 00h and the output port is 01h. So sysResetN=1, gateA20=0, irq=0, both inhibit outputs are 0 and kbdTxValid=0.
- R2: The status byte is {4'b0, cmdFlag, sysFlag, inFull, outFull}, with outFull at bit 0. An accepted write sets inFull (bit 1) until the next cycle, when it is consumed. It sets cmdFlag (bit 3) to 1 for a command-port write and 0 for a data-port write. A write made while inFull is set is ignored.
- R3: Command 20h loads the configuration byte into the output buffer. Command 60h makes the next data byte load the configuration byte. Status bit 2 follows configuration bit 2.
- R4: Commands ADh/AEh set/clear configuration bit 4, which drives kbdInhibit. Commands A7h/A8h set/clear bit 5, which drives auxInhibit.
- R5: Command AAh loads 55h into the output buffer.
- R6: Command D1h makes the next data byte load the output port, whose bit 0 drives sysResetN and bit 1 drives gateA20. Command D0h loads the output port into the output buffer.
- R7: Command D2h makes the next data byte appear in the output buffer as though it came from the device.
- R8: A command Fxh drives low, for PULSE_CYCLES cycles, each output-port bit among 0–3 whose command bit is 0. Command D0h still returns the unpulsed port value.
- R9: A data byte with no armed wait is forwarded as a single-cycle kbdTxValid pulse carrying the byte.
- R10: Status bit 0 is set while the output buffer holds data. irq equals that bit ANDed with configuration bit 0. A CPU read of the data port empties the buffer.
- R11: A device byte loads the output buffer only when it is empty. It is dropped when the buffer is full, or when the controller loads the buffer in the same cycle.
- R12: A command-port write cancels any armed data wait. A command code with no defined action changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| cpuSelCmd | input | 1 | Port select: 1 = command/status, 0 = data |
| cpuWdata | input | 8 | CPU write byte |
| cpuRdata | output | 8 | Status byte or output buffer, chosen by cpuSelCmd |
| devValid | input | 1 | A byte from the device side is offered |
| devData | input | 8 | Device-side byte |
| kbdTxValid | output | 1 | One-cycle strobe: forward a byte to the keyboard |
| kbdTxData | output | 8 | Byte forwarded to the keyboard |
| irq | output | 1 | Output-buffer-full interrupt request |
| sysResetN | output | 1 | System reset, active low |
| gateA20 | output | 1 | Address line 20 gate |
| kbdInhibit | output | 1 | Hold the keyboard clock low |
| auxInhibit | output | 1 | Hold the auxiliary clock low |

## Verification
The bench writes a data byte in the cycle right after a command, while the input buffer is still full. A design that accepted it would load the configuration byte with the wrong value or forward a stray byte to the keyboard. It arms a configuration load and then sends a new command before the data byte. A design that kept the old wait would swallow the byte instead of forwarding it. It offers a device byte while the output buffer is full, which catches designs that overwrite unread data. It counts the low time of a reset pulse edge to edge and checks that an unselected line stays high, which exposes off-by-one counters and inverted masks.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] CMD_RD_CFG    = 8'h20;
  localparam logic [7:0] CMD_WR_CFG    = 8'h60;
  localparam logic [7:0] CMD_AUX_OFF   = 8'hA7;
  localparam logic [7:0] CMD_AUX_ON    = 8'hA8;
  localparam logic [7:0] CMD_SELFTEST  = 8'hAA;
  localparam logic [7:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [7:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [7:0] CMD_RD_OPORT  = 8'hD0;
  localparam logic [7:0] CMD_WR_OPORT  = 8'hD1;
  localparam logic [7:0] CMD_LOOPBACK  = 8'hD2;
  localparam logic [3:0] CMD_PULSE_HI  = 4'hF;

  localparam logic [7:0] SELFTEST_PASS = 8'h55;
  localparam int         KBD_INH_BIT   = 4;
  localparam int         AUX_INH_BIT   = 5;
  localparam int         IRQ_EN_BIT    = 0;
  localparam int         SYS_FLAG_BIT  = 2;

  typedef enum logic [1:0] {
    OB_CFG,
    OB_SELFTEST,
    OB_OPORT,
    OB_INBUF
  } obSrc_e;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_CFG,
    PEND_OPORT,
    PEND_LOOP
  } pend_e;

  typedef struct packed {
    logic              ibfClear;
    logic              obLoad;
    obSrc_e            obSrc;
    logic              cfgLoad;
    logic              cfgSet;
    logic              cfgClr;
    logic [BYTE_W-1:0] cfgMask;
    logic              opLoad;
    logic              kbdSend;
    logic              pulseStart;
    logic [3:0]        pulseMask;
  } ctlStrb_t;
endpackage

// File: rtl/kbc_ctrl.sv
module kbc_ctrl
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ibf,
  input  logic              cmdFlag,
  input  logic [BYTE_W-1:0] inBuf,
  output ctlStrb_t          strb
);
  pend_e pend, pendNext;

  always_comb begin
    strb       = '0;
    strb.obSrc = OB_CFG;
    pendNext   = pend;
    if (ibf) begin
      strb.ibfClear = 1'b1;
      pendNext      = PEND_NONE;
      if (cmdFlag) begin
        if (inBuf[7:4] == CMD_PULSE_HI) begin
          strb.pulseStart = 1'b1;
          strb.pulseMask  = ~inBuf[3:0];
        end else begin
          case (inBuf)
            CMD_RD_CFG:   begin strb.obLoad = 1'b1; strb.obSrc = OB_CFG; end
            CMD_WR_CFG:   pendNext = PEND_CFG;
            CMD_SELFTEST: begin strb.obLoad = 1'b1; strb.obSrc = OB_SELFTEST; end
            CMD_KBD_OFF:  begin strb.cfgSet = 1'b1; strb.cfgMask[KBD_INH_BIT] = 1'b1; end
            CMD_KBD_ON:   begin strb.cfgClr = 1'b1; strb.cfgMask[KBD_INH_BIT] = 1'b1; end
            CMD_AUX_OFF:  begin strb.cfgSet = 1'b1; strb.cfgMask[AUX_INH_BIT] = 1'b1; end
            CMD_AUX_ON:   begin strb.cfgClr = 1'b1; strb.cfgMask[AUX_INH_BIT] = 1'b1; end
            CMD_RD_OPORT: begin strb.obLoad = 1'b1; strb.obSrc = OB_OPORT; end
            CMD_WR_OPORT: pendNext = PEND_OPORT;
            CMD_LOOPBACK: pendNext = PEND_LOOP;
            default:      ;
          endcase
        end
      end else begin
        case (pend)
          PEND_CFG:   strb.cfgLoad = 1'b1;
          PEND_OPORT: strb.opLoad  = 1'b1;
          PEND_LOOP:  begin strb.obLoad = 1'b1; strb.obSrc = OB_INBUF; end
          default:    strb.kbdSend = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pend <= PEND_NONE;
    else       pend <= pendNext;
  end

  // R12
  pend_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pend != $past(pend)) |-> $past(ibf));

  // R9
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.obLoad, strb.cfgLoad, strb.opLoad, strb.kbdSend}) <= 1);
endmodule

// File: rtl/kbc_datapath.sv
module kbc_datapath
  import kbc_pkg::*;
#(
  parameter int              PULSE_CYCLES = 600,
  parameter logic [BYTE_W-1:0] CFG_RST    = 8'h00,
  parameter logic [BYTE_W-1:0] OPORT_RST  = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic              cpuSelCmd,
  input  logic [BYTE_W-1:0] cpuWdata,
  output logic [BYTE_W-1:0] cpuRdata,
  input  logic              devValid,
  input  logic [BYTE_W-1:0] devData,
  input  ctlStrb_t          strb,
  output logic              ibf,
  output logic              cmdFlag,
  output logic [BYTE_W-1:0] inBuf,
  output logic              kbdTxValid,
  output logic [BYTE_W-1:0] kbdTxData,
  output logic              irq,
  output logic              sysResetN,
  output logic              gateA20,
  output logic              kbdInhibit,
  output logic              auxInhibit
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

  logic              obf;
  logic [BYTE_W-1:0] outBuf, obNext, cfgByte, outPort, statusByte;
  logic [CNT_W-1:0]  pulseCnt;
  logic [3:0]        pulseBits;
  logic              pulseOn, wrAccept, dataRead;

  assign wrAccept = cpuWr && !ibf;
  assign dataRead = cpuRd && !cpuSelCmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibf     <= 1'b0;
      cmdFlag <= 1'b0;
      inBuf   <= '0;
    end else if (wrAccept) begin
      ibf     <= 1'b1;
      cmdFlag <= cpuSelCmd;
      inBuf   <= cpuWdata;
    end else if (strb.ibfClear) begin
      ibf     <= 1'b0;
    end
  end

  always_comb begin
    case (strb.obSrc)
      OB_CFG:      obNext = cfgByte;
      OB_SELFTEST: obNext = SELFTEST_PASS;
      OB_OPORT:    obNext = outPort;
      default:     obNext = inBuf;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      obf    <= 1'b0;
      outBuf <= '0;
    end else if (strb.obLoad) begin
      obf    <= 1'b1;
      outBuf <= obNext;
    end else if (devValid && !obf) begin
      obf    <= 1'b1;
      outBuf <= devData;
    end else if (dataRead) begin
      obf    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgByte <= CFG_RST;
    end else if (strb.cfgLoad) begin
      cfgByte <= inBuf;
    end else if (strb.cfgSet) begin
      cfgByte <= cfgByte | strb.cfgMask;
    end else if (strb.cfgClr) begin
      cfgByte <= cfgByte & ~strb.cfgMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            outPort <= OPORT_RST;
    else if (strb.opLoad) outPort <= inBuf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kbdTxValid <= 1'b0;
      kbdTxData  <= '0;
    end else begin
      kbdTxValid <= strb.kbdSend;
      if (strb.kbdSend) kbdTxData <= inBuf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt  <= '0;
      pulseBits <= '0;
    end else if (strb.pulseStart) begin
      pulseCnt  <= CNT_W'(PULSE_CYCLES);
      pulseBits <= strb.pulseMask;
    end else if (pulseCnt != '0) begin
      pulseCnt  <= pulseCnt - 1'b1;
    end
  end

  assign pulseOn    = (pulseCnt != '0);
  assign statusByte = {4'b0000, cmdFlag, cfgByte[SYS_FLAG_BIT], ibf, obf};
  assign cpuRdata   = cpuSelCmd ? statusByte : outBuf;
  assign irq        = obf && cfgByte[IRQ_EN_BIT];
  assign sysResetN  = outPort[0] && !(pulseOn && pulseBits[0]);
  assign gateA20    = outPort[1] && !(pulseOn && pulseBits[1]);
  assign kbdInhibit = cfgByte[KBD_INH_BIT];
  assign auxInhibit = cfgByte[AUX_INH_BIT];

  // R2
  in_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !ibf) |=> (ibf && cmdFlag == $past(cpuSelCmd)));

  // R2
  busy_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && ibf) |=> $stable(inBuf));

  // R10
  read_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && obf && !strb.obLoad) |=> !obf);

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (obf && !strb.obLoad) |=> $stable(outBuf));

  // R3
  cfg_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgByte) |-> $past(ibf));

  // R9
  fwd_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    kbdTxValid |-> ($past(ibf) && !$past(cmdFlag)));
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter int              PULSE_CYCLES = 600,
  parameter logic [7:0]      CFG_RST      = 8'h00,
  parameter logic [7:0]      OPORT_RST    = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic       cpuSelCmd,
  input  logic [7:0] cpuWdata,
  output logic [7:0] cpuRdata,
  input  logic       devValid,
  input  logic [7:0] devData,
  output logic       kbdTxValid,
  output logic [7:0] kbdTxData,
  output logic       irq,
  output logic       sysResetN,
  output logic       gateA20,
  output logic       kbdInhibit,
  output logic       auxInhibit
);
  ctlStrb_t          strb;
  logic              ibf, cmdFlag;
  logic [BYTE_W-1:0] inBuf;

  kbc_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ibf     (ibf),
    .cmdFlag (cmdFlag),
    .inBuf   (inBuf),
    .strb    (strb)
  );

  kbc_datapath #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .CFG_RST      (CFG_RST),
    .OPORT_RST    (OPORT_RST)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cpuWr      (cpuWr),
    .cpuRd      (cpuRd),
    .cpuSelCmd  (cpuSelCmd),
    .cpuWdata   (cpuWdata),
    .cpuRdata   (cpuRdata),
    .devValid   (devValid),
    .devData    (devData),
    .strb       (strb),
    .ibf        (ibf),
    .cmdFlag    (cmdFlag),
    .inBuf      (inBuf),
    .kbdTxValid (kbdTxValid),
    .kbdTxData  (kbdTxData),
    .irq        (irq),
    .sysResetN  (sysResetN),
    .gateA20    (gateA20),
    .kbdInhibit (kbdInhibit),
    .auxInhibit (auxInhibit)
  );
endmodule

// File: tb/test_kbc_host_regs.sv
module test_kbc_host_regs;
  localparam int PULSE = 12;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWr = 1'b0, cpuRd = 1'b0, cpuSelCmd = 1'b0;
  logic [7:0] cpuWdata = '0, devData = '0;
  logic       devValid = 1'b0;
  logic [7:0] cpuRdata, kbdTxData;
  logic       kbdTxValid, irq, sysResetN, gateA20, kbdInhibit, auxInhibit;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  logic [7:0] fwdQ[$];

  always #5 clk = ~clk;

  kbc_host_regs #(.PULSE_CYCLES(PULSE)) i_kbc_host_regs (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuSelCmd(cpuSelCmd),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .devValid(devValid), .devData(devData),
    .kbdTxValid(kbdTxValid), .kbdTxData(kbdTxData), .irq(irq), .sysResetN(sysResetN),
    .gateA20(gateA20), .kbdInhibit(kbdInhibit), .auxInhibit(auxInhibit)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected keyboard bytes as the design forwards them (R9)
  always @(negedge clk) begin
    if (rstN && kbdTxValid === 1'b1) begin
      if (fwdQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 act=%02h exp=none", kbdTxData);
      end else begin
        chk("R9 forwarded byte", kbdTxData, fwdQ.pop_front());
      end
    end
  end

  // write, peek the status while the byte waits, then let it be consumed
  task automatic hostWrite(input logic isCmd, input logic [7:0] val,
                           input logic expectFwd, output logic [7:0] stPeek);
    if (expectFwd) fwdQ.push_back(val);
    @(negedge clk);
    cpuWr = 1'b1; cpuSelCmd = isCmd; cpuWdata = val;
    @(negedge clk);
    cpuWr = 1'b0; cpuSelCmd = 1'b1;
    #1 stPeek = cpuRdata;
    @(negedge clk);
  endtask

  task automatic hostRead(input logic isCmd, output logic [7:0] val);
    @(negedge clk);
    cpuSelCmd = isCmd;
    #1 val = cpuRdata;
    cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    #1;
  endtask

  task automatic devSend(input logic [7:0] val);
    @(negedge clk);
    devValid = 1'b1; devData = val;
    @(negedge clk);
    devValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] st, rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cpuSelCmd = 1'b1; #1;
    // R1 reset state
    chk("R1 status", cpuRdata, 8'h00);
    chk("R1 pins", {2'b0, kbdTxValid, irq, sysResetN, gateA20, kbdInhibit, auxInhibit}, 8'h08);

    // R9 + R2: plain data byte is forwarded; status shows data in buffer
    hostWrite(1'b0, 8'hED, 1'b1, st);
    chk("R2 data write status", st, 8'h02);

    // R5, R10
    hostWrite(1'b1, 8'hAA, 1'b0, st);
    chk("R2 command write status", st, 8'h0A);
    hostRead(1'b1, rd); chk("R10 status full", rd, 8'h09);
    chk("R10 irq disabled", {7'b0, irq}, 8'h00);
    hostRead(1'b0, rd); chk("R5 self test", rd, 8'h55);
    hostRead(1'b1, rd); chk("R10 read empties", rd, 8'h08);

    // R3 write configuration 05h
    hostWrite(1'b1, 8'h60, 1'b0, st);
    hostWrite(1'b0, 8'h05, 1'b0, st);
    hostRead(1'b1, rd); chk("R3 sys flag", rd, 8'h04);
    hostWrite(1'b1, 8'h20, 1'b0, st);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    hostRead(1'b1, rd); chk("R3 status", rd, 8'h0D);
    hostRead(1'b0, rd); chk("R3 read cfg", rd, 8'h05);
    chk("R10 irq off", {7'b0, irq}, 8'h00);

    // R11 device bytes
    devSend(8'h1C);
    chk("R11 irq from device", {7'b0, irq}, 8'h01);
    devSend(8'h2D);
    hostRead(1'b0, rd); chk("R11 full keeps first", rd, 8'h1C);
    hostRead(1'b1, rd); chk("R11 empty after read", rd[0], 1'b0);

    // R4 inhibit bits
    hostWrite(1'b1, 8'hAD, 1'b0, st);
    hostWrite(1'b1, 8'hA7, 1'b0, st);
    chk("R4 inhibits set", {6'b0, kbdInhibit, auxInhibit}, 8'h03);
    hostWrite(1'b1, 8'h20, 1'b0, st);
    hostRead(1'b0, rd); chk("R4 cfg bits", rd, 8'h35);
    hostWrite(1'b1, 8'hAE, 1'b0, st);
    chk("R4 kbd clear", {6'b0, kbdInhibit, auxInhibit}, 8'h01);
    hostWrite(1'b1, 8'hA8, 1'b0, st);
    chk("R4 aux clear", {6'b0, kbdInhibit, auxInhibit}, 8'h00);

    // R6 output port
    hostWrite(1'b1, 8'hD1, 1'b0, st);
    hostWrite(1'b0, 8'h03, 1'b0, st);
    chk("R6 pins", {6'b0, sysResetN, gateA20}, 8'h03);
    hostWrite(1'b1, 8'hD0, 1'b0, st);
    hostRead(1'b0, rd); chk("R6 read port", rd, 8'h03);

    // R7 loopback
    hostWrite(1'b1, 8'hD2, 1'b0, st);
    hostWrite(1'b0, 8'hA5, 1'b0, st);
    hostRead(1'b0, rd); chk("R7 loopback", rd, 8'hA5);

    // R2 write while input buffer busy is ignored
    @(negedge clk);
    cpuWr = 1'b1; cpuSelCmd = 1'b1; cpuWdata = 8'h60;
    @(negedge clk);
    cpuSelCmd = 1'b0; cpuWdata = 8'h99;
    @(negedge clk);
    cpuWr = 1'b0;
    hostWrite(1'b0, 8'h81, 1'b0, st);
    hostWrite(1'b1, 8'h20, 1'b0, st);
    hostRead(1'b0, rd); chk("R2 busy write ignored", rd, 8'h81);
    hostWrite(1'b1, 8'h60, 1'b0, st);
    hostWrite(1'b0, 8'h05, 1'b0, st);

    // R12 a command cancels an armed wait
    hostWrite(1'b1, 8'h60, 1'b0, st);
    hostWrite(1'b1, 8'hAA, 1'b0, st);
    hostWrite(1'b0, 8'h77, 1'b1, st);
    hostRead(1'b0, rd); chk("R12 new command ran", rd, 8'h55);
    hostWrite(1'b1, 8'h20, 1'b0, st);
    hostRead(1'b0, rd); chk("R12 cfg untouched", rd, 8'h05);

    // R12 unknown command
    hostWrite(1'b1, 8'h12, 1'b0, st);
    hostRead(1'b1, rd); chk("R12 unknown no load", rd, 8'h0C);
    chk("R12 unknown pins", {4'b0, sysResetN, gateA20, kbdInhibit, auxInhibit}, 8'h0C);

    // R8 pulse bits 0,2,3 (command F2h)
    hostWrite(1'b1, 8'hF2, 1'b0, st);
    chk("R8 pulse start", {6'b0, sysResetN, gateA20}, 8'h01);
    repeat (PULSE - 1) @(negedge clk);
    chk("R8 pulse last cycle", {6'b0, sysResetN, gateA20}, 8'h01);
    @(negedge clk);
    chk("R8 pulse end", {6'b0, sysResetN, gateA20}, 8'h03);
    hostWrite(1'b1, 8'hD0, 1'b0, st);
    hostRead(1'b0, rd); chk("R8 port unchanged", rd, 8'h03);

    repeat (3) @(negedge clk);
    chk("R9 all forwarded", 8'(fwdQ.size()), 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule